// File: doc/BRIEF.md
# Host-to-Storage-Controller Mailbox

This block sits between an 8-bit host CPU and a storage-controller microcontroller. It gives them a small set of byte registers to pass commands and data to each other. The host uses its I/O bus and sees three consecutive ports starting at a base port (0x40 by default):

- The command port takes a command byte.
- The data port carries bytes in both directions.
- The status port reports flags that the host polls.

The controller sees four word addresses on a synchronous register port. With these it collects the command, takes bytes the host wrote, supplies bytes for the host to read, raises a busy indication and clears the overrun indication.

Every flag is a set/clear bit:

- One side's write raises the flag.
- The other side's consuming access clears it.
- When a raise and a clear fall in the same cycle, the raise wins, so no byte hand-off is lost.

Read data on both sides is combinational from the address. Only strobes change state, so polling the status port has no side effect.

Top module: `host_ctl_mailbox`

## Requirements
- R1: Synchronous active-high reset clears every flag, the command byte and both data bytes to zero, so the status reads 0x00.
- R2: A host write to port BASE+0 (0x40), made while command-pending is clear, stores the byte and sets command-pending (status bit 0). A controller read of address 0 returns that byte and clears command-pending.
- R3: A host write to port BASE+0 while command-pending is set leaves the command byte unchanged and sets the sticky overrun flag (status bit 7). The flag stays set until the controller writes to address 3 with data bit 7 = 1.
- R4: A host write to port BASE+1 (0x41) stores the byte and sets data-full (status bit 1). A controller read of address 1 returns it and clears data-full. When a host write and a controller read fall in the same cycle, data-full stays set.
- R5: A controller write to address 1 stores the byte and sets data-available (status bit 2). A host read of port BASE+1 returns it and clears data-available. When both fall in the same cycle, data-available stays set.
- R6: The status byte is {overrun, 3'b000, busy, available, full, pending} from bit 7 down to bit 0. It is returned by a host read of port BASE+2 (0x42) and by a controller read of address 2.
- R7: Busy (status bit 3) takes bit 0 of every controller write to address 3.
- R8: Host decoding uses only the low 8 address bits. A host access to any other port changes no state, and a host read of such a port returns 0x00.
- R9: Read data on both sides is valid in the same cycle as the address. A 128-byte transfer in each direction arrives complete and in order under flag-based flow control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Host I/O address (low 8 bits decoded) |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rdata | output | 8 | Host read data |
| ctl_addr | input | 2 | Controller register address: 0 command, 1 data, 2 status, 3 control |
| ctl_rd | input | 1 | Controller read strobe |
| ctl_wr | input | 1 | Controller write strobe |
| ctl_wdata | input | 8 | Controller write data |
| ctl_rdata | output | 8 | Controller read data |

## Verification
The bench builds the block with its defaults: a 16-bit host address and base port 0x40. The 16-bit address lets the bench put non-zero upper bits on the three real ports and probe neighbouring ports 0x3F and 0x43, which exercises aliasing and the no-effect cases. With the fixed base, the hard-coded status values in the directed checks line up with the bit layout in the requirements. A behavioural model compares both read buses on every clock. A two-direction 128-byte exchange with random controller delays checks byte order against queues, including same-cycle set/clear collisions.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int PORT_W = 8;
    localparam int BYTE_W = 8;
    localparam int NFLAG  = 4;

    localparam int FLG_PEND  = 0;
    localparam int FLG_FULL  = 1;
    localparam int FLG_AVAIL = 2;
    localparam int FLG_OVR   = 3;

    localparam int CTRL_BUSY_BIT    = 0;
    localparam int CTRL_CLR_OVR_BIT = 7;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic       overrun;
        logic [2:0] rsvd;
        logic       busy;
        logic       avail;
        logic       full;
        logic       pend;
    } mbx_status_t;

    typedef enum logic [1:0] {HP_CMD = 2'd0, HP_DATA = 2'd1, HP_STAT = 2'd2, HP_NONE = 2'd3} host_port_e;
    typedef enum logic [1:0] {CP_CMD = 2'd0, CP_DATA = 2'd1, CP_STAT = 2'd2, CP_CTRL = 2'd3} ctl_port_e;

    function automatic host_port_e decode_port(input logic [PORT_W-1:0] low,
                                               input logic [PORT_W-1:0] base);
        if (low == base)                         return HP_CMD;
        else if (low == PORT_W'(base + 8'd1))    return HP_DATA;
        else if (low == PORT_W'(base + 8'd2))    return HP_STAT;
        else                                     return HP_NONE;
    endfunction

    function automatic mbx_status_t pack_status(input logic pend, input logic full,
                                                input logic avail, input logic busy,
                                                input logic overrun);
        mbx_status_t s;
        s.overrun = overrun;
        s.rsvd    = 3'b000;
        s.busy    = busy;
        s.avail   = avail;
        s.full    = full;
        s.pend    = pend;
        return s;
    endfunction

endpackage

// File: rtl/mbx_flag.sv
module mbx_flag #(
    parameter bit SET_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (SET_WINS) begin
            if (set)      q <= 1'b1;
            else if (clr) q <= 1'b0;
        end else begin
            if (clr)      q <= 1'b0;
            else if (set) q <= 1'b1;
        end
    end
endmodule

// File: rtl/mbx_host_decode.sv
module mbx_host_decode
    import mbx_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [PORT_W-1:0] BASE_PORT = 8'h40
) (
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    output host_port_e        port,
    output logic              cmd_wr,
    output logic              dat_wr,
    output logic              dat_rd,
    output logic              hit
);
    generate
        if (ADDR_W > PORT_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^host_addr[ADDR_W-1:PORT_W];
        end
    endgenerate

    always_comb begin
        port   = decode_port(host_addr[PORT_W-1:0], BASE_PORT);
        cmd_wr = host_wr && (port == HP_CMD);
        dat_wr = host_wr && (port == HP_DATA);
        dat_rd = host_rd && (port == HP_DATA);
        hit    = (host_rd || host_wr) && (port != HP_NONE);
    end
endmodule

// File: rtl/host_ctl_mailbox.sv
module host_ctl_mailbox
    import mbx_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [PORT_W-1:0] BASE_PORT = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    input  logic              host_rd,
    input  logic              host_wr,
    output logic [7:0]        host_rdata,
    input  logic [1:0]        ctl_addr,
    input  logic              ctl_rd,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    output logic [7:0]        ctl_rdata
);
    host_port_e  hport;
    ctl_port_e   cport;
    logic        host_cmd_wr, host_dat_wr, host_dat_rd, host_hit;
    logic        ctl_cmd_rd, ctl_dat_rd, ctl_dat_wr, ctl_ctrl_wr;
    logic [NFLAG-1:0] flg_set, flg_clr, flg_q;
    byte_t       cmd_q, h2c_q, c2h_q;
    logic        busy_q;
    mbx_status_t stat_q;

    mbx_host_decode #(.ADDR_W(ADDR_W), .BASE_PORT(BASE_PORT)) u_dec (
        .host_addr (host_addr),
        .host_rd   (host_rd),
        .host_wr   (host_wr),
        .port      (hport),
        .cmd_wr    (host_cmd_wr),
        .dat_wr    (host_dat_wr),
        .dat_rd    (host_dat_rd),
        .hit       (host_hit)
    );

    always_comb begin
        cport       = ctl_port_e'(ctl_addr);
        ctl_cmd_rd  = ctl_rd && (cport == CP_CMD);
        ctl_dat_rd  = ctl_rd && (cport == CP_DATA);
        ctl_dat_wr  = ctl_wr && (cport == CP_DATA);
        ctl_ctrl_wr = ctl_wr && (cport == CP_CTRL);
    end

    always_comb begin
        flg_set[FLG_PEND]  = host_cmd_wr && !flg_q[FLG_PEND];
        flg_clr[FLG_PEND]  = ctl_cmd_rd;
        flg_set[FLG_FULL]  = host_dat_wr;
        flg_clr[FLG_FULL]  = ctl_dat_rd;
        flg_set[FLG_AVAIL] = ctl_dat_wr;
        flg_clr[FLG_AVAIL] = host_dat_rd;
        flg_set[FLG_OVR]   = host_cmd_wr && flg_q[FLG_PEND];
        flg_clr[FLG_OVR]   = ctl_ctrl_wr && ctl_wdata[CTRL_CLR_OVR_BIT];
    end

    generate
        for (genvar g = 0; g < NFLAG; g++) begin : g_flag
            mbx_flag #(.SET_WINS(1'b1)) u_flag (
                .clk (clk),
                .rst (rst),
                .set (flg_set[g]),
                .clr (flg_clr[g]),
                .q   (flg_q[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            h2c_q  <= '0;
            c2h_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            if (flg_set[FLG_PEND]) cmd_q  <= host_wdata;
            if (host_dat_wr)       h2c_q  <= host_wdata;
            if (ctl_dat_wr)        c2h_q  <= ctl_wdata;
            if (ctl_ctrl_wr)       busy_q <= ctl_wdata[CTRL_BUSY_BIT];
        end
    end

    always_comb begin
        stat_q = pack_status(flg_q[FLG_PEND], flg_q[FLG_FULL], flg_q[FLG_AVAIL],
                             busy_q, flg_q[FLG_OVR]);
    end

    always_comb begin
        unique case (hport)
            HP_CMD:  host_rdata = cmd_q;
            HP_DATA: host_rdata = c2h_q;
            HP_STAT: host_rdata = stat_q;
            default: host_rdata = '0;
        endcase
        unique case (cport)
            CP_CMD:  ctl_rdata = cmd_q;
            CP_DATA: ctl_rdata = h2c_q;
            CP_STAT: ctl_rdata = stat_q;
            default: ctl_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker (
    input logic       clk,
    input logic       rst,
    input logic       host_cmd_wr,
    input logic       host_dat_wr,
    input logic       host_dat_rd,
    input logic       host_hit,
    input logic       ctl_cmd_rd,
    input logic       ctl_dat_rd,
    input logic       ctl_dat_wr,
    input logic       ctl_rd,
    input logic       ctl_wr,
    input logic [7:0] host_wdata,
    input logic [7:0] cmd_q,
    input logic [7:0] status
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (status == 8'h00));

    a_r2_cmd_accept: assert property (@(posedge clk) disable iff (rst)
        (host_cmd_wr && !status[0]) |=> (status[0] && cmd_q == $past(host_wdata)));

    a_r3_cmd_overrun: assert property (@(posedge clk) disable iff (rst)
        (host_cmd_wr && status[0]) |=> (status[7] && cmd_q == $past(cmd_q)));

    a_r4_full_set: assert property (@(posedge clk) disable iff (rst)
        host_dat_wr |=> status[1]);

    a_r4_full_clear: assert property (@(posedge clk) disable iff (rst)
        (ctl_dat_rd && !host_dat_wr) |=> !status[1]);

    a_r5_avail_clear: assert property (@(posedge clk) disable iff (rst)
        (host_dat_rd && !ctl_dat_wr) |=> !status[2]);

    a_r2_pend_clear: assert property (@(posedge clk) disable iff (rst)
        (ctl_cmd_rd && !host_cmd_wr) |=> !status[0]);

    a_r8_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!host_hit && !ctl_rd && !ctl_wr) |=> ($stable(status) && $stable(cmd_q)));

    a_r6_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        status[6:4] == 3'b000);
endmodule

bind host_ctl_mailbox mbx_checker u_mbx_checker (
    .clk         (clk),
    .rst         (rst),
    .host_cmd_wr (host_cmd_wr),
    .host_dat_wr (host_dat_wr),
    .host_dat_rd (host_dat_rd),
    .host_hit    (host_hit),
    .ctl_cmd_rd  (ctl_cmd_rd),
    .ctl_dat_rd  (ctl_dat_rd),
    .ctl_dat_wr  (ctl_dat_wr),
    .ctl_rd      (ctl_rd),
    .ctl_wr      (ctl_wr),
    .host_wdata  (host_wdata),
    .cmd_q       (cmd_q),
    .status      (stat_q)
);

// File: tb/test_host_ctl_mailbox.sv
`timescale 1ns/1ps
module test_host_ctl_mailbox;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] host_addr = 16'h0042;
    logic [7:0]  host_wdata = 8'h00;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0]  host_rdata;
    logic [1:0]  ctl_addr = 2'd2;
    logic        ctl_rd = 1'b0, ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = 8'h00;
    logic [7:0]  ctl_rdata;

    int nchk = 0, nfail = 0;
    bit mon_en = 1'b0;

    // behavioural reference model
    logic [7:0] m_cmd, m_h2c, m_c2h;
    bit m_pend, m_full, m_avail, m_busy, m_over;
    logic [7:0] q_h2c[$], q_c2h[$];

    always #4 clk = ~clk;

    host_ctl_mailbox i_host_ctl_mailbox (
        .clk(clk), .rst(rst),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_wr(host_wr), .host_rdata(host_rdata),
        .ctl_addr(ctl_addr), .ctl_rd(ctl_rd), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata)
    );

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_stat();
        return {m_over, 3'b000, m_busy, m_avail, m_full, m_pend};
    endfunction

    function automatic logic [7:0] exp_host(input logic [7:0] p);
        case (p)
            8'h40:   return m_cmd;
            8'h41:   return m_c2h;
            8'h42:   return m_stat();
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_ctl(input logic [1:0] a);
        case (a)
            2'd0:    return m_cmd;
            2'd1:    return m_h2c;
            2'd2:    return m_stat();
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cmd = 0; m_h2c = 0; m_c2h = 0;
            m_pend = 0; m_full = 0; m_avail = 0; m_busy = 0; m_over = 0;
        end else begin
            bit hcw, hdw, hdr, ccr, cdr, cdw, ccw;
            hcw = host_wr && host_addr[7:0] == 8'h40;
            hdw = host_wr && host_addr[7:0] == 8'h41;
            hdr = host_rd && host_addr[7:0] == 8'h41;
            ccr = ctl_rd && ctl_addr == 2'd0;
            cdr = ctl_rd && ctl_addr == 2'd1;
            cdw = ctl_wr && ctl_addr == 2'd1;
            ccw = ctl_wr && ctl_addr == 2'd3;
            if (ccw && ctl_wdata[7]) m_over = 0;
            if (hcw && m_pend)       m_over = 1;
            if (ccw)                 m_busy = ctl_wdata[0];
            if (hcw && !m_pend) begin m_cmd = host_wdata; m_pend = 1; end
            else if (ccr)            m_pend = 0;
            if (hdw) begin m_full = 1; m_h2c = host_wdata; end
            else if (cdr)            m_full = 0;
            if (cdw) begin m_avail = 1; m_c2h = ctl_wdata; end
            else if (hdr)            m_avail = 0;
        end
    end

    // every-clock comparison of both read buses against the model (R9)
    always @(negedge clk) begin
        #3;
        if (mon_en && !rst) begin
            check("R9 host_rdata vs model", host_rdata, exp_host(host_addr[7:0]));
            check("R9 ctl_rdata vs model", ctl_rdata, exp_ctl(ctl_addr));
        end
    end

    task automatic host_io(input bit wr, input logic [15:0] a, input logic [7:0] d,
                           output logic [7:0] rd);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = wr; host_rd = !wr;
        #3 rd = host_rdata;
        @(posedge clk);
        #1 host_wr = 1'b0; host_rd = 1'b0;
    endtask

    task automatic ctl_io(input bit wr, input logic [1:0] a, input logic [7:0] d,
                          output logic [7:0] rd);
        @(negedge clk);
        ctl_addr = a; ctl_wdata = d; ctl_wr = wr; ctl_rd = !wr;
        #3 rd = ctl_rdata;
        @(posedge clk);
        #1 ctl_wr = 1'b0; ctl_rd = 1'b0; ctl_addr = 2'd2;
    endtask

    task automatic host_stat(input string tag, input logic [7:0] exp);
        logic [7:0] r;
        host_io(1'b0, 16'h0042, 8'h00, r);
        check(tag, r, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog R9 actual=hung expected=complete");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        mon_en = 1'b1;

        host_stat("R1 status after reset", 8'h00);
        ctl_io(1'b0, 2'd2, 8'h00, r); check("R1 ctl status after reset", r, 8'h00);
        ctl_io(1'b0, 2'd1, 8'h00, r); check("R1 data byte after reset", r, 8'h00);

        host_io(1'b1, 16'h0040, 8'h5A, r);
        host_stat("R2 R6 pending bit0", 8'h01);
        ctl_io(1'b0, 2'd0, 8'h00, r); check("R2 ctl reads command", r, 8'h5A);
        host_stat("R2 pending cleared", 8'h00);

        host_io(1'b1, 16'h0040, 8'h11, r);
        host_io(1'b1, 16'h0040, 8'h22, r);
        host_stat("R3 overrun bit7 and pending", 8'h81);
        ctl_io(1'b0, 2'd0, 8'h00, r); check("R3 first command kept", r, 8'h11);
        host_stat("R3 overrun sticky", 8'h80);
        ctl_io(1'b1, 2'd3, 8'h80, r);
        host_stat("R3 overrun cleared", 8'h00);

        ctl_io(1'b1, 2'd3, 8'h01, r);
        host_stat("R7 R6 busy bit3", 8'h08);
        ctl_io(1'b1, 2'd3, 8'h00, r);
        host_stat("R7 busy cleared", 8'h00);

        host_io(1'b1, 16'h0041, 8'hC3, r);
        host_stat("R4 full bit1", 8'h02);
        ctl_io(1'b0, 2'd1, 8'h00, r); check("R4 ctl reads data", r, 8'hC3);
        host_stat("R4 full cleared", 8'h00);

        ctl_io(1'b1, 2'd1, 8'h3C, r);
        host_stat("R5 avail bit2", 8'h04);
        host_io(1'b0, 16'h0041, 8'h00, r); check("R5 host reads data", r, 8'h3C);
        host_stat("R5 avail cleared", 8'h00);

        host_io(1'b1, 16'h0043, 8'hFF, r);
        host_io(1'b1, 16'h003F, 8'hFF, r);
        host_stat("R8 writes to other ports ignored", 8'h00);
        ctl_io(1'b1, 2'd1, 8'h99, r);
        host_io(1'b0, 16'h0043, 8'h00, r); check("R8 other port reads zero", r, 8'h00);
        host_stat("R8 other port read keeps avail", 8'h04);
        host_io(1'b0, 16'h0541, 8'h00, r); check("R8 alias read data", r, 8'h99);
        host_stat("R8 alias read cleared avail", 8'h00);
        host_io(1'b1, 16'h1240, 8'h77, r);
        host_stat("R8 alias command write", 8'h01);
        ctl_io(1'b0, 2'd0, 8'h00, r); check("R8 alias command byte", r, 8'h77);

        host_io(1'b1, 16'h0041, 8'h10, r);
        fork
            begin logic [7:0] x; host_io(1'b1, 16'h0041, 8'h20, x); end
            begin logic [7:0] y; ctl_io(1'b0, 2'd1, 8'h00, y); check("R4 collision ctl old byte", y, 8'h10); end
        join
        host_stat("R4 collision full stays set", 8'h02);
        ctl_io(1'b0, 2'd1, 8'h00, r); check("R4 collision new byte", r, 8'h20);

        ctl_io(1'b1, 2'd1, 8'hA1, r);
        fork
            begin logic [7:0] x; ctl_io(1'b1, 2'd1, 8'hA2, x); end
            begin logic [7:0] y; host_io(1'b0, 16'h0041, 8'h00, y); check("R5 collision host old byte", y, 8'hA1); end
        join
        host_stat("R5 collision avail stays set", 8'h04);
        host_io(1'b0, 16'h0041, 8'h00, r); check("R5 collision new byte", r, 8'hA2);

        // sector exchange host -> controller
        fork
            begin
                logic [7:0] s;
                host_io(1'b1, 16'h0040, 8'h21, s);
                for (int i = 0; i < 128; i++) begin
                    do host_io(1'b0, 16'h0042, 8'h00, s); while (s[1]);
                    host_io(1'b1, 16'h0041, 8'(i * 7 + 3), s);
                    q_h2c.push_back(8'(i * 7 + 3));
                end
            end
            begin
                logic [7:0] s;
                do ctl_io(1'b0, 2'd2, 8'h00, s); while (!s[0]);
                ctl_io(1'b0, 2'd0, 8'h00, s); check("R2 exchange command", s, 8'h21);
                for (int i = 0; i < 128; i++) begin
                    repeat ($urandom_range(0, 5)) @(posedge clk);
                    do ctl_io(1'b0, 2'd2, 8'h00, s); while (!s[1]);
                    ctl_io(1'b0, 2'd1, 8'h00, s);
                    check("R4 R9 h2c byte order", s, q_h2c.pop_front());
                end
            end
        join

        // sector exchange controller -> host
        fork
            begin
                logic [7:0] s;
                for (int i = 0; i < 128; i++) begin
                    repeat ($urandom_range(0, 5)) @(posedge clk);
                    do ctl_io(1'b0, 2'd2, 8'h00, s); while (s[2]);
                    ctl_io(1'b1, 2'd1, 8'(8'hFF - i * 5), s);
                    q_c2h.push_back(8'(8'hFF - i * 5));
                end
            end
            begin
                logic [7:0] s;
                for (int i = 0; i < 128; i++) begin
                    do host_io(1'b0, 16'h0042, 8'h00, s); while (!s[2]);
                    host_io(1'b0, 16'h0041, 8'h00, s);
                    check("R5 R9 c2h byte order", s, q_c2h.pop_front());
                end
            end
        join
        host_stat("R9 idle after exchange", 8'h00);

        rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        host_stat("R1 status after second reset", 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule